// File: doc/BRIEF.md
# Sparse-Space Bus Address Translator

This block sits between a host port and a 32-bit peripheral bus. A host that wants a byte, halfword or three-byte access in a sparse window does not use byte strobes. It places the access size and the starting byte lane inside the address and issues one 32-bit access. The translator takes that request and finds which window it falls in: one of three memory windows or the I/O window. It then works out the active-low lane strobes from the low address bits and forms the peripheral address by dropping the five low host bits. For the first memory window, the top peripheral address bits come from a small extension register.

Each accepted request produces at most one peripheral cycle and exactly one response. On a read, the bus word is right-aligned so the requested bytes sit in the low lanes. A request with a size/lane pair that is not supported, or that falls in no window, gets an error response with no peripheral cycle.

Top module: `sparse_bus_xlate`

## Requirements
- R1: Windows are matched on the high host bits: memory window A at 0x80_0000_0000 spans 2^34 bytes (29 offset bits), B at 0x84_0000_0000 spans 2^32 (27 bits), C at 0x85_0000_0000 spans 2^31 (26 bits), I/O at 0x85_8000_0000 spans 2^31 (26 bits). An address in no window, including any with host bit 39 clear, returns rsp_err=1 and rsp_data all ones, with no bus cycle.
- R2: Host bits 4:3 give the size (00 one byte, 01 two, 10 three, 11 four) and bits 6:5 the starting lane L. The valid pairs and their strobes (bus_be_n, bit 0 = lane 0, active low) are: byte L=0..3 → 1110, 1101, 1011, 0111; two bytes L=0 → 1100 and L=2 → 0011; three bytes L=0 → 1000 and L=1 → 0001; four bytes L=2 → 0000.
- R3: Any other size/lane pair, including two bytes at L=1, returns rsp_err=1 and rsp_data all ones, and starts no bus cycle.
- R4: bus_addr bits N-1:2 equal host bits N+4:7, where N is the window's offset width, and bus_addr bits 1:0 are zero. For windows B, C and I/O, the bus_addr bits above N are zero.
- R5: For window A, bus_addr bits 31:29 carry the extension register value.
- R6: A pulse on ext_we loads ext_wdata into the extension register. A request keeps the extension value it saw when it was accepted, even if the register is written later while its bus cycle is still waiting.
- R7: bus_write follows req_write, and bus_wdata carries req_wdata unchanged. The requester has already copied the datum across the lanes.
- R8: Read response data is the bus word shifted right by 8×L and then masked to the access size: 8, 16 or 24 bits. Four-byte reads are returned unshifted. A write response returns zero data with rsp_err=0.
- R9: Only one request is in flight. req_ready is low from the acceptance edge until the response is taken. bus_valid, bus_addr, bus_be_n and bus_wdata hold steady until bus_ready.
- R10: rsp_valid, rsp_data and rsp_err hold steady until rsp_ready is seen.
- R11: After reset, req_ready=1, bus_valid=0 and rsp_valid=0. A bus cycle and a response are never presented in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_we | input | 1 | Extension register write strobe |
| ext_wdata | input | EXT_W (3) | Extension register write value |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Translator can accept a request |
| req_addr | input | HOST_AW (40) | Host sparse address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW (32) | Lane-replicated write data |
| bus_valid | output | 1 | Peripheral cycle pending |
| bus_ready | input | 1 | Peripheral cycle completes |
| bus_write | output | 1 | Peripheral cycle direction |
| bus_addr | output | BUS_AW (32) | Peripheral address |
| bus_be_n | output | DW/8 (4) | Active-low lane strobes |
| bus_wdata | output | DW (32) | Peripheral write data |
| bus_rdata | input | DW (32) | Peripheral read data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | DW (32) | Right-aligned read data |
| rsp_err | output | 1 | Request rejected |

## Verification
The in-RTL properties check the handshake rules on every cycle. These are: the single-outstanding rule, that the bus and response signals stay steady while stalled, that a bus cycle and a response never overlap, that error responses carry all-ones data, and that bus addresses are word aligned with at least one lane strobe active. Whether the right window, strobe pattern, extension bits and read alignment are produced for a given address can only be shown by the directed scenarios. The same holds for the rule that a mid-flight extension write leaves the pending cycle alone.

// File: rtl/sbx_pkg.sv
package sbx_pkg;

   typedef enum logic [1:0] {
      SZ_ONE   = 2'b00,
      SZ_TWO   = 2'b01,
      SZ_THREE = 2'b10,
      SZ_FOUR  = 2'b11
   } xfer_size_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'b00,
      ST_BUS  = 2'b01,
      ST_RESP = 2'b10
   } xl_state_e;

   localparam int unsigned NUM_WIN  = 4;
   localparam int unsigned NUM_LANE = 4;
   localparam int unsigned FLD_LSB  = 3;
   localparam int unsigned LANE_LSB = 5;
   localparam int unsigned WORD_LSB = 7;

   typedef struct packed {
      logic                legal;
      logic [NUM_LANE-1:0] be_n;
      logic [1:0]          shift;
      logic [1:0]          keep_m1;
   } lane_info_t;

endpackage

// File: rtl/sbx_win_match.sv
module sbx_win_match #(
   parameter int unsigned HOST_AW  = 40,
   parameter int unsigned BUS_AW   = 32,
   parameter int unsigned OFS_BITS = 29,
   parameter logic [HOST_AW-1:0] BASE = 40'h80_0000_0000
) (
   input  logic [HOST_AW-8:0] word_addr,
   output logic               hit,
   output logic [BUS_AW-1:0]  offset
);
   localparam int unsigned SPAN = OFS_BITS + 5;

   if (SPAN >= HOST_AW) begin : g_bad_span
      $error("window span does not fit the host address");
   end
   if (BASE[SPAN-1:0] != '0) begin : g_bad_base
      $error("window base not aligned to its span");
   end

   assign hit = (word_addr[HOST_AW-8:SPAN-7] == BASE[HOST_AW-1:SPAN]);

   always_comb begin
      offset = '0;
      offset[OFS_BITS-1:2] = word_addr[OFS_BITS-3:0];
   end
endmodule

// File: rtl/sbx_win_dec.sv
module sbx_win_dec
   import sbx_pkg::*;
#(
   parameter int unsigned HOST_AW = 40,
   parameter int unsigned BUS_AW  = 32,
   parameter int unsigned EXT_W   = 3,
   parameter logic [NUM_WIN-1:0][HOST_AW-1:0] WIN_BASE = '0,
   parameter logic [NUM_WIN-1:0][7:0]         WIN_BITS = '0
) (
   input  logic [HOST_AW-8:0] word_addr,
   input  logic [EXT_W-1:0]   ext_val,
   output logic               any_hit,
   output logic [BUS_AW-1:0]  bus_addr
);
   localparam int unsigned A_BITS = int'(WIN_BITS[0]);

   if (A_BITS + EXT_W != BUS_AW) begin : g_bad_ext
      $error("extension width plus window A offset must fill the bus address");
   end

   logic [NUM_WIN-1:0] hits;
   logic [BUS_AW-1:0]  ofs [NUM_WIN];
   logic [BUS_AW-1:0]  pick;
   logic               use_ext;

   for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
      if (WIN_BASE[g][HOST_AW-1] != 1'b1) begin : g_bad_top
         $error("window base must have the uncached top bit set");
      end
      if (int'(WIN_BITS[g]) > BUS_AW || int'(WIN_BITS[g]) < 3) begin : g_bad_bits
         $error("window offset width out of range");
      end
      sbx_win_match #(
         .HOST_AW (HOST_AW),
         .BUS_AW  (BUS_AW),
         .OFS_BITS(int'(WIN_BITS[g])),
         .BASE    (WIN_BASE[g])
      ) i_match (
         .word_addr(word_addr),
         .hit      (hits[g]),
         .offset   (ofs[g])
      );
   end

   // lowest index wins if windows were ever configured to overlap
   always_comb begin
      any_hit = |hits;
      pick    = '0;
      use_ext = 1'b0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hits[i]) begin
            pick    = ofs[i];
            use_ext = (i == 0);
         end
      end
   end

   assign bus_addr = use_ext ? {ext_val, pick[A_BITS-1:0]} : pick;
endmodule

// File: rtl/sbx_lane_dec.sv
module sbx_lane_dec
   import sbx_pkg::*;
(
   input  logic [1:0]  size_fld,
   input  logic [1:0]  lane_fld,
   output lane_info_t  info
);
   logic [4:0] run;

   always_comb begin
      info       = '0;
      info.be_n  = '1;
      info.shift = lane_fld;
      unique case (xfer_size_e'(size_fld))
         SZ_ONE: begin
            info.legal   = 1'b1;
            info.keep_m1 = 2'd0;
         end
         SZ_TWO: begin
            info.legal   = ~lane_fld[0];
            info.keep_m1 = 2'd1;
         end
         SZ_THREE: begin
            info.legal   = ~lane_fld[1];
            info.keep_m1 = 2'd2;
         end
         SZ_FOUR: begin
            info.legal   = (lane_fld == 2'b10);
            info.keep_m1 = 2'd3;
            info.shift   = 2'd0;
         end
         default: info.legal = 1'b0;
      endcase
      run = (5'd1 << ({3'd0, info.keep_m1} + 5'd1)) - 5'd1;
      if (info.legal) info.be_n = ~(run[3:0] << info.shift);
   end
endmodule

// File: rtl/sbx_rd_align.sv
module sbx_rd_align
   import sbx_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic [DW-1:0] raw,
   input  logic [1:0]    shift,
   input  logic [1:0]    keep_m1,
   output logic [DW-1:0] aligned
);
   if (DW != 8 * NUM_LANE) begin : g_bad_dw
      $error("data width must equal four lanes");
   end

   logic [DW-1:0] shifted;
   assign shifted = raw >> {shift, 3'b000};

   for (genvar b = 0; b < NUM_LANE; b++) begin : g_lane
      assign aligned[8*b +: 8] = (b <= int'(keep_m1)) ? shifted[8*b +: 8] : 8'h00;
   end
endmodule

// File: rtl/sparse_bus_xlate.sv
module sparse_bus_xlate
   import sbx_pkg::*;
#(
   parameter int unsigned HOST_AW = 40,
   parameter int unsigned BUS_AW  = 32,
   parameter int unsigned DW      = 32,
   parameter int unsigned A_BITS  = 29,
   parameter int unsigned B_BITS  = 27,
   parameter int unsigned C_BITS  = 26,
   parameter int unsigned IO_BITS = 26,
   parameter logic [HOST_AW-1:0] A_BASE  = 40'h80_0000_0000,
   parameter logic [HOST_AW-1:0] B_BASE  = 40'h84_0000_0000,
   parameter logic [HOST_AW-1:0] C_BASE  = 40'h85_0000_0000,
   parameter logic [HOST_AW-1:0] IO_BASE = 40'h85_8000_0000,
   parameter int unsigned EXT_W   = BUS_AW - A_BITS
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ext_we,
   input  logic [EXT_W-1:0]   ext_wdata,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [HOST_AW-1:0] req_addr,
   input  logic               req_write,
   input  logic [DW-1:0]      req_wdata,
   output logic               bus_valid,
   input  logic               bus_ready,
   output logic               bus_write,
   output logic [BUS_AW-1:0]  bus_addr,
   output logic [DW/8-1:0]    bus_be_n,
   output logic [DW-1:0]      bus_wdata,
   input  logic [DW-1:0]      bus_rdata,
   output logic               rsp_valid,
   input  logic               rsp_ready,
   output logic [DW-1:0]      rsp_data,
   output logic               rsp_err
);
   localparam int unsigned NLANE = DW / 8;
   localparam logic [NUM_WIN-1:0][HOST_AW-1:0] WIN_BASE = {IO_BASE, C_BASE, B_BASE, A_BASE};
   localparam logic [NUM_WIN-1:0][7:0] WIN_BITS =
      {8'(IO_BITS), 8'(C_BITS), 8'(B_BITS), 8'(A_BITS)};

   if (DW != 32) begin : g_bad_dw
      $error("data width must be 32");
   end
   if (HOST_AW <= WORD_LSB + 1) begin : g_bad_haw
      $error("host address too narrow");
   end

   xl_state_e          state_q;
   logic [EXT_W-1:0]   ext_q;
   logic               hit_any;
   logic [BUS_AW-1:0]  xl_addr;
   lane_info_t         linfo;
   logic [DW-1:0]      rd_aligned;
   logic [BUS_AW-1:0]  addr_q;
   logic [NLANE-1:0]   be_n_q;
   logic [DW-1:0]      wdata_q;
   logic               write_q;
   logic [1:0]         shift_q;
   logic [1:0]         keep_q;
   logic [DW-1:0]      rsp_data_q;
   logic               rsp_err_q;
   logic               accept;

   sbx_win_dec #(
      .HOST_AW (HOST_AW),
      .BUS_AW  (BUS_AW),
      .EXT_W   (EXT_W),
      .WIN_BASE(WIN_BASE),
      .WIN_BITS(WIN_BITS)
   ) i_win_dec (
      .word_addr(req_addr[HOST_AW-1:WORD_LSB]),
      .ext_val  (ext_q),
      .any_hit  (hit_any),
      .bus_addr (xl_addr)
   );

   sbx_lane_dec i_lane_dec (
      .size_fld(req_addr[FLD_LSB +: 2]),
      .lane_fld(req_addr[LANE_LSB +: 2]),
      .info    (linfo)
   );

   sbx_rd_align #(.DW(DW)) i_rd_align (
      .raw    (bus_rdata),
      .shift  (shift_q),
      .keep_m1(keep_q),
      .aligned(rd_aligned)
   );

   assign accept = (state_q == ST_IDLE) && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ext_q <= '0;
      else if (ext_we) ext_q <= ext_wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         addr_q     <= '0;
         be_n_q     <= '1;
         wdata_q    <= '0;
         write_q    <= 1'b0;
         shift_q    <= '0;
         keep_q     <= '0;
         rsp_data_q <= '0;
         rsp_err_q  <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (accept) begin
               if (hit_any && linfo.legal) begin
                  addr_q  <= xl_addr;
                  be_n_q  <= linfo.be_n;
                  wdata_q <= req_wdata;
                  write_q <= req_write;
                  shift_q <= linfo.shift;
                  keep_q  <= linfo.keep_m1;
                  state_q <= ST_BUS;
               end else begin
                  rsp_data_q <= '1;
                  rsp_err_q  <= 1'b1;
                  state_q    <= ST_RESP;
               end
            end
            ST_BUS: if (bus_ready) begin
               rsp_data_q <= write_q ? '0 : rd_aligned;
               rsp_err_q  <= 1'b0;
               state_q    <= ST_RESP;
            end
            ST_RESP: if (rsp_ready) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign bus_valid = (state_q == ST_BUS);
   assign rsp_valid = (state_q == ST_RESP);
   assign bus_write = write_q;
   assign bus_addr  = addr_q;
   assign bus_be_n  = be_n_q;
   assign bus_wdata = wdata_q;
   assign rsp_data  = rsp_data_q;
   assign rsp_err   = rsp_err_q;

   // R9: acceptance closes the request port
   p_one_outstanding_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_ready);
   // R9: stalled bus cycle stays put
   p_bus_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr)
         && $stable(bus_be_n) && $stable(bus_wdata) && $stable(bus_write));
   // R10: stalled response stays put
   p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_err));
   // R3: rejected requests carry all-ones data
   p_err_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && rsp_err |-> (&rsp_data));
   // R4: bus address is word aligned
   p_addr_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_addr[1:0] == 2'b00));
   // R2: an issued cycle enables at least one lane
   p_lane_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> !(&bus_be_n));
   // R11: bus cycle and response never overlap
   p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_valid && rsp_valid));
endmodule

// File: tb/test_sparse_bus_xlate.sv
module test_sparse_bus_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ext_we = 1'b0;
   logic [2:0]  ext_wdata = '0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [39:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [31:0] req_wdata = '0;
   logic        bus_valid;
   logic        bus_ready = 1'b0;
   logic        bus_write;
   logic [31:0] bus_addr;
   logic [3:0]  bus_be_n;
   logic [31:0] bus_wdata;
   logic [31:0] bus_rdata = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_data;
   logic        rsp_err;

   int n_cmp = 0;
   int n_mis = 0;

   localparam logic [39:0] WA  = 40'h80_0000_0000;
   localparam logic [39:0] WB  = 40'h84_0000_0000;
   localparam logic [39:0] WC  = 40'h85_0000_0000;
   localparam logic [39:0] WIO = 40'h85_8000_0000;
   localparam logic [31:0] RD  = 32'hA1B2_C3D4;

   always #10 clk = ~clk;

   sparse_bus_xlate i_sparse_bus_xlate (.*);

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_mis++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [39:0] mk(input logic [39:0] base, input logic [31:0] woff,
                                      input logic [1:0] lane, input logic [1:0] sz);
      return base | ({8'd0, woff} << 7) | (40'(lane) << 5) | (40'(sz) << 3);
   endfunction

   function automatic logic [31:0] exp_addr(input logic [39:0] a, input int bits,
                                            input logic [2:0] ext, input logic use_ext);
      logic [39:0] t;
      t = (a >> 5) & ((40'd1 << bits) - 1);
      t[1:0] = 2'b00;
      if (use_ext) t[31:29] = ext;
      return t[31:0];
   endfunction

   function automatic logic [3:0] exp_be(input logic [1:0] sz, input logic [1:0] lane);
      case ({sz, lane})
         4'b0000: return 4'b1110;
         4'b0001: return 4'b1101;
         4'b0010: return 4'b1011;
         4'b0011: return 4'b0111;
         4'b0100: return 4'b1100;
         4'b0110: return 4'b0011;
         4'b1000: return 4'b1000;
         4'b1001: return 4'b0001;
         4'b1110: return 4'b0000;
         default: return 4'b1111;
      endcase
   endfunction

   function automatic logic [31:0] exp_rd(input logic [31:0] raw, input logic [1:0] sz,
                                          input logic [1:0] lane);
      logic [31:0] s;
      if (sz == 2'b11) return raw;
      s = raw >> (8 * lane);
      case (sz)
         2'b00:   return s & 32'h0000_00FF;
         2'b01:   return s & 32'h0000_FFFF;
         default: return s & 32'h00FF_FFFF;
      endcase
   endfunction

   task automatic set_ext(input logic [2:0] v);
      @(negedge clk); ext_we = 1'b1; ext_wdata = v;
      @(negedge clk); ext_we = 1'b0;
   endtask

   task automatic access(input logic [39:0] a, input logic wr, input logic [31:0] wd,
                         input logic [31:0] rd, input int wait_cyc,
                         input logic mid_ext, input logic [2:0] mid_val,
                         output logic saw_bus, output logic [31:0] b_addr,
                         output logic [3:0] b_be, output logic [31:0] b_wd,
                         output logic b_wr, output logic [31:0] r_data, output logic r_err);
      @(negedge clk);
      req_addr = a; req_write = wr; req_wdata = wd; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R9 busy after accept", 64'(req_ready), 64'd0);
      saw_bus = bus_valid;
      b_addr = bus_addr; b_be = bus_be_n; b_wd = bus_wdata; b_wr = bus_write;
      if (bus_valid) begin
         if (mid_ext) begin ext_we = 1'b1; ext_wdata = mid_val; end
         for (int k = 0; k < wait_cyc; k++) begin
            @(negedge clk);
            ext_we = 1'b0;
            chk("R9 bus hold", {31'd0, bus_valid, bus_addr}, {31'd0, 1'b1, b_addr});
         end
         bus_rdata = rd; bus_ready = 1'b1;
         @(negedge clk);
         bus_ready = 1'b0; ext_we = 1'b0;
      end
      chk("R10 response present", 64'(rsp_valid), 64'd1);
      r_data = rsp_data; r_err = rsp_err;
      @(negedge clk);
      chk("R10 response hold", {rsp_valid, rsp_err, rsp_data}, {1'b1, r_err, r_data});
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk("R9 ready after response", 64'(req_ready), 64'd1);
   endtask

   task automatic t_reset;
      chk("R11 reset req_ready", 64'(req_ready), 64'd1);
      chk("R11 reset bus_valid", 64'(bus_valid), 64'd0);
      chk("R11 reset rsp_valid", 64'(rsp_valid), 64'd0);
   endtask

   task automatic t_lanes;
      logic sb, bw, er; logic [31:0] ba, wd, rd; logic [3:0] be;
      for (int sz = 0; sz < 4; sz++) begin
         for (int ln = 0; ln < 4; ln++) begin
            logic [39:0] a;
            a = mk(WA, 32'h1234 + sz * 4 + ln, 2'(ln), 2'(sz));
            access(a, 1'b0, 32'h0, RD, ln % 2, 1'b0, 3'd0, sb, ba, be, wd, bw, rd, er);
            if (exp_be(2'(sz), 2'(ln)) != 4'b1111) begin
               chk("R2 bus cycle issued", 64'(sb), 64'd1);
               chk("R2 lane strobes", 64'(be), 64'(exp_be(2'(sz), 2'(ln))));
               chk("R4 address", 64'(ba), 64'(exp_addr(a, 29, 3'd0, 1'b1)));
               chk("R8 read align", {31'd0, er, rd}, {31'd0, 1'b0, exp_rd(RD, 2'(sz), 2'(ln))});
            end else begin
               chk("R3 no bus cycle", 64'(sb), 64'd0);
               chk("R3 error response", {31'd0, er, rd}, {31'd0, 1'b1, 32'hFFFF_FFFF});
            end
         end
      end
   endtask

   task automatic t_windows;
      logic sb, bw, er; logic [31:0] ba, wd, rd; logic [3:0] be;
      logic [39:0] a;
      a = mk(WB, 32'h3F_FFFF, 2'd1, 2'd0);
      access(a, 1'b1, 32'h5A5A_5A5A, RD, 1, 1'b0, 3'd0, sb, ba, be, wd, bw, rd, er);
      chk("R1 window B hit", 64'(sb), 64'd1);
      chk("R4 window B address", 64'(ba), 64'(exp_addr(a, 27, 3'd0, 1'b0)));
      chk("R7 write flag", 64'(bw), 64'd1);
      chk("R7 write data", 64'(wd), 64'h5A5A_5A5A);
      chk("R8 write response", {31'd0, er, rd}, 64'd0);
      a = mk(WC, 32'h00AB_CDEF, 2'd0, 2'd1);
      access(a, 1'b1, 32'hBEEF_BEEF, RD, 0, 1'b0, 3'd0, sb, ba, be, wd, bw, rd, er);
      chk("R1 window C hit", 64'(sb), 64'd1);
      chk("R4 window C address", 64'(ba), 64'(exp_addr(a, 26, 3'd0, 1'b0)));
      chk("R7 write data C", 64'(wd), 64'hBEEF_BEEF);
      a = mk(WIO, 32'h00FF_FFFF, 2'd2, 2'd3);
      access(a, 1'b0, 32'h0, RD, 2, 1'b0, 3'd0, sb, ba, be, wd, bw, rd, er);
      chk("R1 I/O hit", 64'(sb), 64'd1);
      chk("R4 I/O address", 64'(ba), 64'(exp_addr(a, 26, 3'd0, 1'b0)));
      chk("R8 four-byte read unshifted", 64'(rd), 64'(RD));
      chk("R7 read flag", 64'(bw), 64'd0);
      a = mk(40'h86_0000_0000, 32'h10, 2'd0, 2'd0);
      access(a, 1'b0, 32'h0, RD, 0, 1'b0, 3'd0, sb, ba, be, wd, bw, rd, er);
      chk("R1 unmapped no cycle", 64'(sb), 64'd0);
      chk("R1 unmapped error", {31'd0, er, rd}, {31'd0, 1'b1, 32'hFFFF_FFFF});
      a = mk(40'h00_0000_0000, 32'h10, 2'd0, 2'd0);
      access(a, 1'b1, 32'h1, RD, 0, 1'b0, 3'd0, sb, ba, be, wd, bw, rd, er);
      chk("R1 top bit clear no cycle", 64'(sb), 64'd0);
      chk("R1 top bit clear error", {31'd0, er, rd}, {31'd0, 1'b1, 32'hFFFF_FFFF});
   endtask

   task automatic t_ext;
      logic sb, bw, er; logic [31:0] ba, wd, rd; logic [3:0] be;
      logic [39:0] a;
      a = mk(WA, 32'h0765_4321, 2'd0, 2'd0);
      set_ext(3'd5);
      access(a, 1'b0, 32'h0, RD, 3, 1'b1, 3'd2, sb, ba, be, wd, bw, rd, er);
      chk("R5 extension bits", 64'(ba), 64'(exp_addr(a, 29, 3'd5, 1'b1)));
      chk("R6 in-flight value kept", 64'(ba[31:29]), 64'd5);
      access(a, 1'b0, 32'h0, RD, 0, 1'b0, 3'd0, sb, ba, be, wd, bw, rd, er);
      chk("R6 new value used next", 64'(ba), 64'(exp_addr(a, 29, 3'd2, 1'b1)));
      a = mk(WB, 32'h0000_0001, 2'd0, 2'd0);
      access(a, 1'b0, 32'h0, RD, 0, 1'b0, 3'd0, sb, ba, be, wd, bw, rd, er);
      chk("R4 extension not applied to B", 64'(ba[31:27]), 64'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_mis++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_lanes();
      t_windows();
      t_ext();
      repeat (2) @(negedge clk);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
   end
endmodule